// File: doc/BRIEF.md
# Reference-Counted Buffer Descriptor Manager

This block owns a pool of packet buffer descriptors that several copies of one packet can share. A descriptor is handed out from a single LIFO free list and starts with a reference count of one. The copy stage then issues copies against the payload descriptor. Each issue can add extra copies to the count. For a copy bound for the queue manager, the block decides whether that copy needs a private header descriptor. The header holds the destination MAC and stats index for that copy only. It is chained in front of the shared payload descriptor, and it is built only when more than one copy of the packet exists. Copies bound for a plugin or for the control CPU never receive a header. This keeps the number of descriptors in use low.

Freeing a descriptor lowers its reference count and returns it to the free list when the count reaches zero. Freeing a header descriptor always returns the header. It then lowers the count of the payload the header points to. The descriptor store is an on-chip array of eight 32-bit words per entry. A read command returns any one of these words. The block accepts one command at a time, with a ready/valid handshake on the command side and a one-cycle response pulse.

Top module: `bufdesc_mgr`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid`, `alloc_empty` and `underflow_err` are 0, and all NUM_DESC indices are free. Successive allocations return indices NUM_DESC-1, NUM_DESC-2, ... down to 0, and a freed index is the next one handed out (LIFO).
- R2: `cmd_op` codes are 0 = allocate, 1 = issue copy, 2 = free, 3 = read word. An allocate with length L initialises the popped descriptor as follows, by read word index (`cmd_sel`):
  - word 0: next-buffer pointer = 0
  - word 1: {buffer size L [31:16], offset 0x018E [15:0]}
  - word 2: {packet size L [31:16], free-list id 0 [15:12], reserved 0 [11:8], reference count 1 [7:0]}
  - word 3: {MAC[47:32] [31:16], stats index [15:0]}, both 0
  - word 4: MAC[31:0] = 0
  - word 5: {EtherType 0x0800 [31:16], 0 [15:0]}
  - word 6: 0
  - word 7: next-packet pointer = 0
- R3: An issue with destination `cmd_sel` = 0 (queue manager) that leaves the count at 1 makes no header (`rsp_hdr` = 0). It writes `cmd_mac` and `cmd_stats` into the payload descriptor.
- R4: An issue to the queue manager that leaves the count above 1 first writes the new count. It then pops a header descriptor and returns it in `rsp_idx` with `rsp_hdr` = 1. The header holds:
  - word 0 = payload index
  - buffer size 0 and offset 0
  - packet size copied from the payload
  - free-list id 0 and reference count 1
  - the command's MAC and stats index
  - EtherType 0x0800
  - next-packet pointer 0

  The payload MAC is left unchanged.
- R5: An issue with destination 1 (plugin) or 2 (control CPU) never makes a header, even when the count is above 1. Every issue adds `cmd_add` to the payload reference count.
- R6: Freeing a header descriptor always returns it to the free list, and it also decrements the payload it points to.
- R7: Freeing a descriptor decrements its count. The descriptor goes back to the free list only when the count reaches zero.
- R8: An allocate, or an issue needing a header, made while the free list is empty is refused (`rsp_refused` = 1) and changes no descriptor. `alloc_empty` is 1 exactly while no index is free.
- R9: Freeing a descriptor whose count is already zero sets `underflow_err`, which stays set until reset, and leaves the count at zero.
- R10: `cmd_ready` is high only when the block is idle. `rsp_valid` is a one-cycle pulse with `cmd_ready` low during it. `rsp_idx` echoes `cmd_idx` for issue (without header), free and read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted this cycle |
| cmd_op | input | 2 | Operation code (R2) |
| cmd_idx | input | IDXW | Descriptor index addressed |
| cmd_sel | input | 3 | Destination for issue, word index for read |
| cmd_add | input | 8 | Extra copies added on issue |
| cmd_len | input | 16 | Packet length for allocate |
| cmd_mac | input | 48 | Destination MAC for a queue-manager copy |
| cmd_stats | input | 16 | Stats index for a queue-manager copy |
| rsp_valid | output | 1 | Response pulse |
| rsp_idx | output | IDXW | Allocated, header or addressed index |
| rsp_hdr | output | 1 | A header descriptor was built |
| rsp_refused | output | 1 | Command refused for lack of a free index |
| rsp_data | output | 32 | Word returned by a read |
| alloc_empty | output | 1 | Free list empty |
| underflow_err | output | 1 | Sticky count-underflow error |

## Verification
The bench builds the block with NUM_DESC = 8, so indices are three bits wide and the free list empties after eight allocations. This makes refusal on an empty list, the reuse of a returned header index and LIFO order over the whole pool reachable in a few dozen commands. The default of 16 is covered only by elaboration. A single payload is driven through every path in turn: single-copy write-back, header creation with the count above one, plugin and CPU copies, header free and last-copy free. After each step, the read command exposes the descriptor words.

// File: rtl/bufdesc_pkg.sv
// Shared types for the buffer descriptor manager: command codes,
// destination codes, the descriptor record and its word view.
package bufdesc_pkg;

    typedef enum logic [1:0] {
        OP_ALLOC = 2'd0,
        OP_ISSUE = 2'd1,
        OP_FREE  = 2'd2,
        OP_READ  = 2'd3
    } bd_op_e;

    localparam logic [2:0]  DST_QMGR   = 3'd0;
    localparam logic [2:0]  DST_PLUGIN = 3'd1;
    localparam logic [2:0]  DST_CPU    = 3'd2;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [3:0]  POOL_ID    = 4'd0;

    // One descriptor as held in the store.
    typedef struct packed {
        logic [31:0] next_buf;
        logic [15:0] buf_size;
        logic [15:0] offset;
        logic [15:0] pkt_size;
        logic [3:0]  pool;
        logic [7:0]  refcnt;
        logic [47:0] mac;
        logic [15:0] stats;
        logic [15:0] etype;
        logic [31:0] next_pkt;
    } bd_desc_t;

    // Word view of a descriptor; field placement is read by software-facing logic.
    function automatic logic [31:0] bd_word(input bd_desc_t d, input logic [2:0] w);
        logic [31:0] r;
        case (w)
            3'd0:    r = d.next_buf;
            3'd1:    r = {d.buf_size, d.offset};
            3'd2:    r = {d.pkt_size, d.pool, 4'd0, d.refcnt};
            3'd3:    r = {d.mac[47:32], d.stats};
            3'd4:    r = d.mac[31:0];
            3'd5:    r = {d.etype, 16'd0};
            3'd6:    r = 32'd0;
            default: r = d.next_pkt;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bd_freelist.sv
// LIFO free list of descriptor indices.
// Assumes: push and pop never in the same cycle; push only while not full.
// Reset loads every index so the highest index is popped first.
module bd_freelist #(
    parameter int NUM_DESC = 16,
    localparam int IDXW = $clog2(NUM_DESC),
    localparam int CNTW = $clog2(NUM_DESC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop,
    input  logic            push,
    input  logic [IDXW-1:0] push_idx,
    output logic [IDXW-1:0] top_idx,
    output logic            empty,
    output logic [CNTW-1:0] count
);
    localparam logic [CNTW-1:0] CNT_ONE  = CNTW'(1);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(NUM_DESC);

    logic [IDXW-1:0] stack [NUM_DESC];
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] cnt_m1;

    // Index just below the stack pointer is the top entry.
    assign cnt_m1  = cnt - CNT_ONE;
    assign top_idx = stack[cnt_m1[IDXW-1:0]];
    assign empty   = (cnt == '0);
    assign count   = cnt;

    // Stack storage and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DESC; i++) begin
                stack[i] <= IDXW'(i);
            end
            cnt <= CNT_FULL;
        end else if (pop && !empty) begin
            cnt <= cnt_m1;
        end else if (push && (cnt != CNT_FULL)) begin
            stack[cnt[IDXW-1:0]] <= push_idx;
            cnt <= cnt + CNT_ONE;
        end
    end

endmodule

// File: rtl/bd_store.sv
// Descriptor store: NUM_DESC records plus a per-entry header marker.
// One combinational read port, one synchronous write port. Reset clears all.
module bd_store
    import bufdesc_pkg::*;
#(
    parameter int NUM_DESC = 16,
    localparam int IDXW = $clog2(NUM_DESC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] raddr,
    output bd_desc_t        rdata,
    output logic            rhdr,
    input  logic            we,
    input  logic [IDXW-1:0] waddr,
    input  bd_desc_t        wdata,
    input  logic            whdr
);
    bd_desc_t            mem [NUM_DESC];
    logic [NUM_DESC-1:0] hdr_q;

    // Combinational read of the addressed entry.
    assign rdata = mem[raddr];
    assign rhdr  = hdr_q[raddr];

    // Whole-record write, or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DESC; i++) begin
                mem[i] <= '0;
            end
            hdr_q <= '0;
        end else if (we) begin
            mem[waddr]   <= wdata;
            hdr_q[waddr] <= whdr;
        end
    end

endmodule

// File: rtl/bd_ctrl.sv
// Command sequencer for the descriptor manager.
// Accepts one command when idle, runs it in one or two work cycles
// (header build and chained free need a second), then pulses a response.
// Assumes the store read is combinational and the free list pops at most
// once per command sequence.
module bd_ctrl
    import bufdesc_pkg::*;
#(
    parameter int          NUM_DESC  = 16,
    parameter logic [15:0] IP_OFFSET = 16'h018E,
    localparam int IDXW = $clog2(NUM_DESC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic [IDXW-1:0] cmd_idx,
    input  logic [2:0]      cmd_sel,
    input  logic [7:0]      cmd_add,
    input  logic [15:0]     cmd_len,
    input  logic [47:0]     cmd_mac,
    input  logic [15:0]     cmd_stats,
    output logic            rsp_valid,
    output logic [IDXW-1:0] rsp_idx,
    output logic            rsp_hdr,
    output logic            rsp_refused,
    output logic [31:0]     rsp_data,
    output logic            underflow_err,
    output logic [IDXW-1:0] st_raddr,
    input  bd_desc_t        st_rdata,
    input  logic            st_rhdr,
    output logic            st_we,
    output logic [IDXW-1:0] st_waddr,
    output bd_desc_t        st_wdata,
    output logic            st_whdr,
    input  logic            fl_empty,
    input  logic [IDXW-1:0] fl_top,
    output logic            fl_pop,
    output logic            fl_push,
    output logic [IDXW-1:0] fl_push_idx
);
    typedef enum logic [2:0] {
        S_IDLE, S_EXEC, S_HDR, S_FREE2, S_RESP
    } state_e;

    state_e          state, nxt;
    bd_op_e          op_q;
    logic [IDXW-1:0] idx_q, tgt_q;
    logic [2:0]      sel_q;
    logic [7:0]      add_q;
    logic [15:0]     len_q;
    logic [47:0]     mac_q;
    logic [15:0]     stats_q;

    logic            ld_rsp, ld_tgt, set_err;
    logic [IDXW-1:0] r_idx;
    logic            r_hdr, r_ref;
    logic [31:0]     r_data;
    logic [7:0]      newcnt;
    bd_desc_t        fresh_d, head_d;

    assign cmd_ready = (state == S_IDLE);
    assign rsp_valid = (state == S_RESP);
    assign newcnt    = st_rdata.refcnt + add_q;

    // Record written on allocation of a payload descriptor.
    always_comb begin
        fresh_d          = '0;
        fresh_d.buf_size = len_q;
        fresh_d.offset   = IP_OFFSET;
        fresh_d.pkt_size = len_q;
        fresh_d.pool     = POOL_ID;
        fresh_d.refcnt   = 8'd1;
        fresh_d.etype    = ETYPE_IPV4;
    end

    // Record written for a private header chained to payload idx_q.
    always_comb begin
        head_d          = '0;
        head_d.next_buf = {{(32-IDXW){1'b0}}, idx_q};
        head_d.pkt_size = st_rdata.pkt_size;
        head_d.pool     = POOL_ID;
        head_d.refcnt   = 8'd1;
        head_d.mac      = mac_q;
        head_d.stats    = stats_q;
        head_d.etype    = ETYPE_IPV4;
    end

    // Next state, store/free-list strobes and response values.
    always_comb begin
        nxt         = state;
        st_raddr    = (state == S_FREE2) ? tgt_q : idx_q;
        st_we       = 1'b0;
        st_waddr    = idx_q;
        st_wdata    = st_rdata;
        st_whdr     = st_rhdr;
        fl_pop      = 1'b0;
        fl_push     = 1'b0;
        fl_push_idx = idx_q;
        set_err     = 1'b0;
        ld_rsp      = 1'b0;
        ld_tgt      = 1'b0;
        r_idx       = idx_q;
        r_hdr       = 1'b0;
        r_ref       = 1'b0;
        r_data      = '0;
        case (state)
            S_IDLE: begin
                if (cmd_valid) nxt = S_EXEC;
            end
            S_EXEC: begin
                ld_rsp = 1'b1;
                nxt    = S_RESP;
                case (op_q)
                    OP_ALLOC: begin
                        if (fl_empty) begin
                            r_ref = 1'b1;
                        end else begin
                            fl_pop   = 1'b1;
                            st_we    = 1'b1;
                            st_waddr = fl_top;
                            st_wdata = fresh_d;
                            st_whdr  = 1'b0;
                            r_idx    = fl_top;
                        end
                    end
                    OP_ISSUE: begin
                        if ((sel_q == DST_QMGR) && (newcnt > 8'd1)) begin
                            if (fl_empty) begin
                                r_ref = 1'b1;
                            end else begin
                                st_we           = 1'b1;
                                st_wdata.refcnt = newcnt;
                                ld_rsp          = 1'b0;
                                nxt             = S_HDR;
                            end
                        end else begin
                            st_we           = 1'b1;
                            st_wdata.refcnt = newcnt;
                            if (sel_q == DST_QMGR) begin
                                st_wdata.mac   = mac_q;
                                st_wdata.stats = stats_q;
                            end
                        end
                    end
                    OP_FREE: begin
                        if (st_rdata.refcnt == 8'd0) begin
                            set_err = 1'b1;
                        end else begin
                            st_we           = 1'b1;
                            st_wdata.refcnt = st_rdata.refcnt - 8'd1;
                            if (st_rhdr) begin
                                fl_push = 1'b1;
                                ld_tgt  = 1'b1;
                                ld_rsp  = 1'b0;
                                nxt     = S_FREE2;
                            end else if (st_rdata.refcnt == 8'd1) begin
                                fl_push = 1'b1;
                            end
                        end
                    end
                    default: begin
                        r_data = bd_word(st_rdata, sel_q);
                    end
                endcase
            end
            S_HDR: begin
                ld_rsp   = 1'b1;
                nxt      = S_RESP;
                fl_pop   = 1'b1;
                st_we    = 1'b1;
                st_waddr = fl_top;
                st_wdata = head_d;
                st_whdr  = 1'b1;
                r_idx    = fl_top;
                r_hdr    = 1'b1;
            end
            S_FREE2: begin
                ld_rsp      = 1'b1;
                nxt         = S_RESP;
                st_waddr    = tgt_q;
                fl_push_idx = tgt_q;
                if (st_rdata.refcnt == 8'd0) begin
                    set_err = 1'b1;
                end else begin
                    st_we           = 1'b1;
                    st_wdata.refcnt = st_rdata.refcnt - 8'd1;
                    fl_push         = (st_rdata.refcnt == 8'd1);
                end
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // Sequencer state and command capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            op_q    <= OP_READ;
            idx_q   <= '0;
            sel_q   <= '0;
            add_q   <= '0;
            len_q   <= '0;
            mac_q   <= '0;
            stats_q <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && cmd_valid) begin
                op_q    <= bd_op_e'(cmd_op);
                idx_q   <= cmd_idx;
                sel_q   <= cmd_sel;
                add_q   <= cmd_add;
                len_q   <= cmd_len;
                mac_q   <= cmd_mac;
                stats_q <= cmd_stats;
            end
        end
    end

    // Chained payload index captured when a header is freed.
    always_ff @(posedge clk) begin
        if (!rst_n)      tgt_q <= '0;
        else if (ld_tgt) tgt_q <= st_rdata.next_buf[IDXW-1:0];
    end

    // Response registers, held until the next command completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_idx     <= '0;
            rsp_hdr     <= 1'b0;
            rsp_refused <= 1'b0;
            rsp_data    <= '0;
        end else if (ld_rsp) begin
            rsp_idx     <= r_idx;
            rsp_hdr     <= r_hdr;
            rsp_refused <= r_ref;
            rsp_data    <= r_data;
        end
    end

    // Sticky underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       underflow_err <= 1'b0;
        else if (set_err) underflow_err <= 1'b1;
    end

endmodule

// File: rtl/bufdesc_mgr.sv
// Top of the reference-counted buffer descriptor manager.
// Joins the sequencer, the descriptor store and the free list.
// Assumes a single requester issuing one command at a time.
module bufdesc_mgr #(
    parameter int          NUM_DESC  = 16,
    parameter logic [15:0] IP_OFFSET = 16'h018E,
    localparam int IDXW = $clog2(NUM_DESC),
    localparam int CNTW = $clog2(NUM_DESC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic [IDXW-1:0] cmd_idx,
    input  logic [2:0]      cmd_sel,
    input  logic [7:0]      cmd_add,
    input  logic [15:0]     cmd_len,
    input  logic [47:0]     cmd_mac,
    input  logic [15:0]     cmd_stats,
    output logic            rsp_valid,
    output logic [IDXW-1:0] rsp_idx,
    output logic            rsp_hdr,
    output logic            rsp_refused,
    output logic [31:0]     rsp_data,
    output logic            alloc_empty,
    output logic            underflow_err
);
    import bufdesc_pkg::*;

    logic [IDXW-1:0] st_raddr, st_waddr;
    bd_desc_t        st_rdata, st_wdata;
    logic            st_rhdr, st_we, st_whdr;
    logic            fl_empty, fl_pop, fl_push;
    logic [IDXW-1:0] fl_top, fl_push_idx;
    logic [CNTW-1:0] fl_count;

    assign alloc_empty = fl_empty;

    bd_ctrl #(.NUM_DESC(NUM_DESC), .IP_OFFSET(IP_OFFSET)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_sel(cmd_sel), .cmd_add(cmd_add),
        .cmd_len(cmd_len), .cmd_mac(cmd_mac), .cmd_stats(cmd_stats),
        .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_hdr(rsp_hdr),
        .rsp_refused(rsp_refused), .rsp_data(rsp_data),
        .underflow_err(underflow_err),
        .st_raddr(st_raddr), .st_rdata(st_rdata), .st_rhdr(st_rhdr),
        .st_we(st_we), .st_waddr(st_waddr), .st_wdata(st_wdata), .st_whdr(st_whdr),
        .fl_empty(fl_empty), .fl_top(fl_top), .fl_pop(fl_pop),
        .fl_push(fl_push), .fl_push_idx(fl_push_idx)
    );

    bd_store #(.NUM_DESC(NUM_DESC)) u_store (
        .clk(clk), .rst_n(rst_n),
        .raddr(st_raddr), .rdata(st_rdata), .rhdr(st_rhdr),
        .we(st_we), .waddr(st_waddr), .wdata(st_wdata), .whdr(st_whdr)
    );

    bd_freelist #(.NUM_DESC(NUM_DESC)) u_freelist (
        .clk(clk), .rst_n(rst_n),
        .pop(fl_pop), .push(fl_push), .push_idx(fl_push_idx),
        .top_idx(fl_top), .empty(fl_empty), .count(fl_count)
    );

endmodule

// File: rtl/bufdesc_mgr_chk.sv
// Property checker for bufdesc_mgr, bound to every instance.
// Observes ports and the free-list occupancy only.
module bufdesc_mgr_chk #(
    parameter int NUM_DESC = 16,
    localparam int CNTW = $clog2(NUM_DESC + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_ready,
    input logic            rsp_valid,
    input logic            rsp_hdr,
    input logic            rsp_refused,
    input logic            alloc_empty,
    input logic            underflow_err,
    input logic [CNTW-1:0] fl_count
);
    localparam logic [CNTW:0]   EXT_ONE  = (CNTW+1)'(1);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(NUM_DESC);

    logic [CNTW:0] cnt_ext;
    assign cnt_ext = {1'b0, fl_count};

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= CNT_FULL);                                              // R7
    AST_REFUSE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_refused) |-> $past(alloc_empty));                 // R8
    AST_HDR_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hdr) |-> ($past(cnt_ext) == cnt_ext + EXT_ONE));  // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);                                   // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                          // R10
    AST_BUSY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);                                          // R10

endmodule

bind bufdesc_mgr bufdesc_mgr_chk #(.NUM_DESC(NUM_DESC)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .rsp_hdr(rsp_hdr), .rsp_refused(rsp_refused), .alloc_empty(alloc_empty),
    .underflow_err(underflow_err), .fl_count(fl_count)
);

// File: tb/bufdesc_mgr_tb_top.sv
// Bench for bufdesc_mgr with an eight-entry pool.
module bufdesc_mgr_tb_top;

    localparam int N = 8;
    localparam int W = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = '0;
    logic [W-1:0]  cmd_idx = '0;
    logic [2:0]    cmd_sel = '0;
    logic [7:0]    cmd_add = '0;
    logic [15:0]   cmd_len = '0;
    logic [47:0]   cmd_mac = '0;
    logic [15:0]   cmd_stats = '0;
    logic          rsp_valid, rsp_hdr, rsp_refused, alloc_empty, underflow_err;
    logic [W-1:0]  rsp_idx;
    logic [31:0]   rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    logic         got_ok, got_ref, got_hdr;
    logic [W-1:0] got_idx;
    logic [31:0]  got_data;

    always #2 clk = ~clk;  // 250 MHz

    bufdesc_mgr #(.NUM_DESC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_sel(cmd_sel), .cmd_add(cmd_add),
        .cmd_len(cmd_len), .cmd_mac(cmd_mac), .cmd_stats(cmd_stats),
        .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_hdr(rsp_hdr),
        .rsp_refused(rsp_refused), .rsp_data(rsp_data),
        .alloc_empty(alloc_empty), .underflow_err(underflow_err)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  idx;
        logic [2:0]  sel;
        logic [7:0]  add;
        logic [15:0] len;
        logic [47:0] mac;
        logic [15:0] stats;
        logic        e_ref;
        logic        e_hdr;
        logic [2:0]  e_idx;
        logic [31:0] e_data;
        logic [3:0]  req;
    } vec_t;

    // op: 0 alloc, 1 issue, 2 free, 3 read; sel: dest (0 qm, 1 plugin, 2 cpu) or word
    localparam vec_t VEC [28] = '{
        '{2'd0,3'd0,3'd0,8'd0,16'd100,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0,4'd2},           // R2 alloc
        '{2'd3,3'd7,3'd1,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0064018E,4'd2},     // R2 w1
        '{2'd3,3'd7,3'd2,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h00640001,4'd2},     // R2 w2
        '{2'd3,3'd7,3'd5,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h08000000,4'd2},     // R2 w5
        '{2'd3,3'd7,3'd0,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0,4'd2},            // R2 w0
        '{2'd1,3'd7,3'd0,8'd0,16'd0,48'h0A0B0C0D0E0F,16'h1234,1'b0,1'b0,3'd7,32'h0,4'd3}, // R3
        '{2'd3,3'd7,3'd3,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0A0B1234,4'd3},     // R3
        '{2'd3,3'd7,3'd4,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0C0D0E0F,4'd3},     // R3
        '{2'd1,3'd7,3'd1,8'd2,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0,4'd5},            // R5 plugin +2
        '{2'd3,3'd7,3'd2,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h00640003,4'd5},     // R5
        '{2'd1,3'd7,3'd0,8'd0,16'd0,48'h112233445566,16'h00AA,1'b0,1'b1,3'd6,32'h0,4'd4}, // R4 header
        '{2'd3,3'd6,3'd0,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd6,32'h00000007,4'd4},     // R4
        '{2'd3,3'd6,3'd1,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd6,32'h0,4'd4},            // R4
        '{2'd3,3'd6,3'd2,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd6,32'h00640001,4'd4},     // R4
        '{2'd3,3'd6,3'd3,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd6,32'h112200AA,4'd4},     // R4
        '{2'd3,3'd6,3'd4,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd6,32'h33445566,4'd4},     // R4
        '{2'd3,3'd6,3'd5,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd6,32'h08000000,4'd4},     // R4
        '{2'd3,3'd6,3'd7,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd6,32'h0,4'd4},            // R4
        '{2'd3,3'd7,3'd3,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0A0B1234,4'd4},     // R4 payload kept
        '{2'd1,3'd7,3'd2,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0,4'd5},            // R5 cpu
        '{2'd3,3'd7,3'd2,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h00640003,4'd5},     // R5
        '{2'd2,3'd6,3'd0,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd6,32'h0,4'd6},            // R6 free hdr
        '{2'd3,3'd7,3'd2,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h00640002,4'd6},     // R6
        '{2'd0,3'd0,3'd0,8'd0,16'h0040,48'h0,16'h0,1'b0,1'b0,3'd6,32'h0,4'd6},         // R6 reuse
        '{2'd3,3'd6,3'd2,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd6,32'h00400001,4'd6},     // R6
        '{2'd2,3'd7,3'd0,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0,4'd7},            // R7 2->1
        '{2'd2,3'd7,3'd0,8'd0,16'd0,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0,4'd7},            // R7 1->0
        '{2'd0,3'd0,3'd0,8'd0,16'h0020,48'h0,16'h0,1'b0,1'b0,3'd7,32'h0,4'd7}          // R7 returned
    };

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [W-1:0] idx, input logic [2:0] sel,
                          input logic [7:0] add, input logic [15:0] len,
                          input logic [47:0] mac, input logic [15:0] stats);
        int n;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_idx = idx; cmd_sel = sel; cmd_add = add;
        cmd_len = len; cmd_mac = mac; cmd_stats = stats; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        got_ok = rsp_valid; got_ref = rsp_refused; got_hdr = rsp_hdr;
        got_idx = rsp_idx; got_data = rsp_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, "ready", 32'(cmd_ready), 32'd1);
        check(1, "rsp_valid", 32'(rsp_valid), 32'd0);
        check(1, "empty", 32'(alloc_empty), 32'd0);
        check(1, "err", 32'(underflow_err), 32'd0);

        for (int i = 0; i < 28; i++) begin
            do_cmd(VEC[i].op, VEC[i].idx, VEC[i].sel, VEC[i].add, VEC[i].len, VEC[i].mac, VEC[i].stats);
            check(int'(VEC[i].req), "response", 32'(got_ok), 32'd1);
            check(int'(VEC[i].req), "refused", 32'(got_ref), 32'(VEC[i].e_ref));
            check(int'(VEC[i].req), "hdr", 32'(got_hdr), 32'(VEC[i].e_hdr));
            check(int'(VEC[i].req), "idx", 32'(got_idx), 32'(VEC[i].e_idx));
            if (VEC[i].op == 2'd3) check(int'(VEC[i].req), "data", got_data, VEC[i].e_data);
        end

        // R10 response lasts one cycle, then ready again
        @(negedge clk);
        check(10, "pulse end", 32'(rsp_valid), 32'd0);
        check(10, "ready again", 32'(cmd_ready), 32'd1);

        // R1 LIFO order over the rest of the pool
        for (int k = 5; k >= 0; k--) begin
            do_cmd(2'd0, 3'd0, 3'd0, 8'd0, 16'h0010, 48'h0, 16'h0);
            check(1, "lifo idx", 32'(got_idx), 32'(k));
        end
        // R8 empty pool refuses
        check(8, "empty flag", 32'(alloc_empty), 32'd1);
        do_cmd(2'd0, 3'd0, 3'd0, 8'd0, 16'h0010, 48'h0, 16'h0);
        check(8, "alloc refused", 32'(got_ref), 32'd1);
        do_cmd(2'd1, 3'd5, 3'd1, 8'd1, 16'h0, 48'h0, 16'h0);
        check(5, "plugin ok when empty", 32'(got_ref), 32'd0);
        do_cmd(2'd1, 3'd5, 3'd0, 8'd0, 16'h0, 48'hFFFFFFFFFFFF, 16'hFFFF);
        check(8, "hdr refused", 32'(got_ref), 32'd1);
        do_cmd(2'd3, 3'd5, 3'd2, 8'd0, 16'h0, 48'h0, 16'h0);
        check(8, "count unchanged", got_data, 32'h00100002);
        do_cmd(2'd3, 3'd5, 3'd3, 8'd0, 16'h0, 48'h0, 16'h0);
        check(8, "mac unchanged", got_data, 32'h0);

        // R7 last copy frees the entry
        do_cmd(2'd2, 3'd0, 3'd0, 8'd0, 16'h0, 48'h0, 16'h0);
        check(7, "empty cleared", 32'(alloc_empty), 32'd0);
        // R9 underflow
        check(9, "no err yet", 32'(underflow_err), 32'd0);
        do_cmd(2'd2, 3'd0, 3'd0, 8'd0, 16'h0, 48'h0, 16'h0);
        check(9, "err set", 32'(underflow_err), 32'd1);
        do_cmd(2'd3, 3'd0, 3'd2, 8'd0, 16'h0, 48'h0, 16'h0);
        check(9, "count stays zero", got_data, 32'h00100000);
        check(9, "err sticky", 32'(underflow_err), 32'd1);

        // R1 reset clears flag and restores pool
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "err after reset", 32'(underflow_err), 32'd0);
        do_cmd(2'd0, 3'd0, 3'd0, 8'd0, 16'h0010, 48'h0, 16'h0);
        check(1, "first idx after reset", 32'(got_idx), 32'd7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule